// File: doc/BRIEF.md
# Buffered Bidirectional-Port Shift Register

This block holds an eight-bit staging register in front of an eight-bit shift register. Both registers share one bidirectional parallel port. The shift register can be filled in three ways: from the staging register, by parallel load, or one bit at a time from either of two serial inputs. It presents its contents on the parallel port, and its top bit on a serial output that is always driven.

The staging register captures whatever is on the port. If the port is released, that is data from outside. If the port is driven, that is the block's own shift contents. So the same pins carry data in and out, and the drive enable decides which way they flow.

Everything runs on one system clock. The two register clocks are slow level inputs. The block passes each through a two-flop synchroniser and acts on the low-to-high change of the synchronised level. The parallel load is level-sensitive and acts only while the synchronised shift clock is low. A dedicated active-low clear empties the shift register at any time, without waiting for a clock.

Top module: `buffered_shift_port`

## Requirements
- R1: On a recognised rising edge of `sh_clk`, with `ld_n` high, `sh_en_n` low and `sr_clr_n` high, the shift register moves one place toward bit 7. Bit n takes bit n-1, and bit 0 takes the selected serial input.
- R2: When `ser_sel` is 0, the serial input is `ser_a`. When `ser_sel` is 1, the serial input is `ser_b`.
- R3: While the synchronised `sh_clk` is low and `ld_n` is low, the shift register takes the staging register contents on every system clock.
- R4: While the synchronised `sh_clk` is high, `ld_n` low has no effect on the shift register.
- R5: On a recognised rising edge of `st_clk`, the staging register captures the port value. That value is `port_in` when `oe_n` is 1, and the shift register contents when `oe_n` is 0.
- R6: `sr_clr_n` low clears the shift register at once, without a clock, and overrides both shift and load. Holding `sr_clr_n` and `ld_n` low together is forbidden; if it happens, clear wins.
- R7: With `sh_en_n` high, edges on `sh_clk` leave the shift register unchanged.
- R8: `port_drv` is 1 exactly when `oe_n` is 0. Shifting, loading and clearing work the same whatever the value of `oe_n`.
- R9: `ser_out` always equals bit 7 of the shift register, which is also `port_out[7]`.
- R10: Each low-to-high change of `sh_clk` causes exactly one shift, however long the clock stays high.
- R11: `sys_rst_n` low clears the synchronisers and the staging register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low system reset for the synchronisers and the staging register |
| st_clk | input | 1 | Staging register clock, sampled as a level |
| sh_clk | input | 1 | Shift clock, sampled as a level |
| sh_en_n | input | 1 | Active-low shift enable |
| ld_n | input | 1 | Active-low parallel load from the staging register |
| sr_clr_n | input | 1 | Active-low asynchronous clear of the shift register |
| ser_sel | input | 1 | Serial source select |
| ser_a | input | 1 | Serial input used when `ser_sel` is 0 |
| ser_b | input | 1 | Serial input used when `ser_sel` is 1 |
| oe_n | input | 1 | Active-low parallel port drive enable |
| port_in | input | WIDTH | Value seen on the port pins |
| port_out | output | WIDTH | Shift register contents offered to the port |
| port_drv | output | 1 | Port drive enable |
| ser_out | output | 1 | Top shift register bit |

## Verification
The embedded assertions check the following on every clock:
- the shift step and its serial source;
- the load from the staging register;
- the hold when no shift or load is qualified;
- the capture source of the staging register;
- the clear;
- the coupling of the serial output to the top bit;
- the ban on clear and load together.

Three behaviours appear only across whole scenarios in the bench:
- one shift per long-held clock pulse;
- the load lockout while the shift clock is high;
- the round trip of external data through the staging register into the shift register and back out of the port.

// File: rtl/buffered_shift_port.sv
module buffered_shift_port #(
  parameter int WIDTH = 8,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             sys_rst_n,
  input  logic             st_clk,
  input  logic             sh_clk,
  input  logic             sh_en_n,
  input  logic             ld_n,
  input  logic             sr_clr_n,
  input  logic             ser_sel,
  input  logic             ser_a,
  input  logic             ser_b,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] port_in,
  output logic [WIDTH-1:0] port_out,
  output logic             port_drv,
  output logic             ser_out
);
  localparam int DEPTH = SYNC + 1;

  logic [DEPTH-1:0] sh_sync, st_sync;
  logic [WIDTH-1:0] stor_q, sh_q, port_val;
  logic             sh_lvl, sh_rise, st_rise, ser_bit;

  assign sh_lvl   = sh_sync[SYNC-1];
  assign sh_rise  = sh_sync[SYNC-1] & ~sh_sync[SYNC];
  assign st_rise  = st_sync[SYNC-1] & ~st_sync[SYNC];
  assign ser_bit  = ser_sel ? ser_b : ser_a;
  assign port_val = oe_n ? port_in : sh_q;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      sh_sync <= '0;
      st_sync <= '0;
      stor_q  <= '0;
    end else begin
      sh_sync <= {sh_sync[DEPTH-2:0], sh_clk};
      st_sync <= {st_sync[DEPTH-2:0], st_clk};
      if (st_rise) stor_q <= port_val;
    end
  end

  always_ff @(posedge clk or negedge sr_clr_n) begin
    if (!sr_clr_n)                          sh_q <= '0;
    else if (!sh_lvl && !ld_n)              sh_q <= stor_q;
    else if (sh_rise && ld_n && !sh_en_n)   sh_q <= {sh_q[WIDTH-2:0], ser_bit};
  end

  assign port_out = sh_q;
  assign port_drv = ~oe_n;
  assign ser_out  = sh_q[WIDTH-1];

  a_r1_shift_step: assert property (@(posedge clk) disable iff (!sys_rst_n || !sr_clr_n)
    (sh_rise && ld_n && !sh_en_n) |=> sh_q == {$past(sh_q[WIDTH-2:0]), $past(ser_bit)});

  a_r2_ser_source: assert property (@(posedge clk) disable iff (!sys_rst_n || !sr_clr_n)
    (sh_rise && ld_n && !sh_en_n) |=> sh_q[0] == ($past(ser_sel) ? $past(ser_b) : $past(ser_a)));

  a_r3_level_load: assert property (@(posedge clk) disable iff (!sys_rst_n || !sr_clr_n)
    (!sh_lvl && !ld_n) |=> sh_q == $past(stor_q));

  a_r7_hold: assert property (@(posedge clk) disable iff (!sys_rst_n || !sr_clr_n)
    (ld_n && (sh_en_n || !sh_rise)) |=> $stable(sh_q));

  a_r5_capture: assert property (@(posedge clk) disable iff (!sys_rst_n)
    st_rise |=> stor_q == $past(port_val));

  a_r6_clear: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !sr_clr_n |-> sh_q == '0);

  a_r6_no_clr_with_ld: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !(!sr_clr_n && !ld_n));

  a_r9_ser_top: assert property (@(posedge clk) disable iff (!sys_rst_n)
    ser_out == port_out[WIDTH-1]);
endmodule

// File: tb/tb_buffered_shift_port.sv
module tb_buffered_shift_port;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, sys_rst_n, st_clk, sh_clk, sh_en_n, ld_n, sr_clr_n;
  logic ser_sel, ser_a, ser_b, oe_n;
  logic [W-1:0] port_in, port_out, exp_q;
  logic port_drv, ser_out;
  int total = 0, bad = 0;

  buffered_shift_port #(.WIDTH(W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sh(int hi);
    sh_clk = 1; cyc(hi); sh_clk = 0; cyc(4);
  endtask

  task automatic pulse_st;
    st_clk = 1; cyc(4); st_clk = 0; cyc(4);
  endtask

  task automatic do_load;
    ld_n = 0; cyc(3); ld_n = 1; cyc(2);
  endtask

  task automatic t_reset;
    sys_rst_n = 0; sr_clr_n = 0; st_clk = 0; sh_clk = 0; sh_en_n = 1; ld_n = 1;
    ser_sel = 0; ser_a = 0; ser_b = 0; oe_n = 0; port_in = '0;
    cyc(4);
    check("R6 clear at reset", port_out, 8'h00);
    check("R9 ser_out at reset", {7'b0, ser_out}, 8'h00);
    check("R8 drive on", {7'b0, port_drv}, 8'h01);
    sys_rst_n = 1; sr_clr_n = 1; cyc(2);
    sh_en_n = 0; ser_a = 1;
    pulse_sh(4); pulse_sh(4);
    check("R1 ones shifted", port_out, 8'h03);
    do_load;
    check("R11 staging zero after reset", port_out, 8'h00);
  endtask

  task automatic t_ext_load;
    oe_n = 1; port_in = 8'hA5; cyc(1);
    check("R8 released", {7'b0, port_drv}, 8'h00);
    pulse_st;
    do_load;
    oe_n = 0; cyc(1);
    check("R3 R5 external through staging", port_out, 8'hA5);
    check("R9 ser_out top", {7'b0, ser_out}, 8'h01);
    exp_q = 8'hA5;
  endtask

  task automatic t_shift;
    ser_sel = 0; ser_a = 1; ser_b = 0; sh_en_n = 0;
    pulse_sh(4); exp_q = {exp_q[W-2:0], 1'b1};
    check("R1 R2 shift from ser_a", port_out, exp_q);
    check("R9 ser_out after shift", {7'b0, ser_out}, {7'b0, exp_q[W-1]});
    ser_sel = 1; ser_a = 1; ser_b = 0;
    pulse_sh(4); exp_q = {exp_q[W-2:0], 1'b0};
    check("R2 shift from ser_b", port_out, exp_q);
    ser_a = 0; ser_b = 1;
    pulse_sh(4); exp_q = {exp_q[W-2:0], 1'b1};
    check("R2 shift from ser_b high", port_out, exp_q);
  endtask

  task automatic t_enable_off;
    sh_en_n = 1;
    pulse_sh(4); pulse_sh(4);
    check("R7 no shift when disabled", port_out, exp_q);
    sh_en_n = 0;
  endtask

  task automatic t_single_edge;
    ser_sel = 0; ser_a = 0;
    pulse_sh(25); exp_q = {exp_q[W-2:0], 1'b0};
    check("R10 one shift per long pulse", port_out, exp_q);
  endtask

  task automatic t_ld_lockout;
    oe_n = 1; port_in = 8'h3C; pulse_st; oe_n = 0;
    sh_en_n = 1;
    sh_clk = 1; cyc(4);
    ld_n = 0; cyc(5);
    check("R4 load locked while shift clock high", port_out, exp_q);
    ld_n = 1; cyc(1);
    sh_clk = 0; cyc(4);
    check("R4 still held after clock low", port_out, exp_q);
    sh_en_n = 0;
    do_load; exp_q = 8'h3C;
    check("R3 load once shift clock low", port_out, exp_q);
  endtask

  task automatic t_self_capture;
    ser_sel = 1; ser_b = 1;
    pulse_sh(4); exp_q = {exp_q[W-2:0], 1'b1};
    oe_n = 0; port_in = 8'hFF; pulse_st;
    pulse_sh(4); pulse_sh(4);
    check("R1 moved before reload", port_out, {exp_q[W-3:0], 2'b11});
    do_load;
    check("R5 staging took own contents", port_out, exp_q);
  endtask

  task automatic t_release;
    oe_n = 1; ser_sel = 0; ser_a = 0;
    pulse_sh(4); exp_q = {exp_q[W-2:0], 1'b0};
    oe_n = 0; cyc(1);
    check("R8 shift works while released", port_out, exp_q);
    oe_n = 1; cyc(1);
    sr_clr_n = 0; #1;
    check("R6 R8 clear while released", port_out, 8'h00);
    cyc(1);
    oe_n = 0;
  endtask

  task automatic t_clear;
    sr_clr_n = 1; ser_a = 1; ser_sel = 0;
    pulse_sh(4);
    check("R1 shift after clear", port_out, 8'h01);
    cyc(1); #2;
    sr_clr_n = 0; #1;
    check("R6 asynchronous clear", port_out, 8'h00);
    sh_clk = 1; cyc(5); sh_clk = 0; cyc(4);
    check("R6 clear overrides shift", port_out, 8'h00);
    sr_clr_n = 1; cyc(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset;
    t_ext_load;
    t_shift;
    t_enable_off;
    t_single_edge;
    t_ld_lockout;
    t_self_capture;
    t_release;
    t_clear;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule